// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzler

This block sits on the request path of a dual-channel memory interface. It rewrites bit 6 of each address for tiled surfaces, so that accesses through the tiled path land in the same channel as accesses made with plain address interleaving. A channel configuration word selects two swizzle modes: one for X-tiled surfaces and one for Y-tiled surfaces. Each mode names which of the address bits 9, 10, 11 and 17 are folded into bit 6 by exclusive-OR.

Requests use a valid/ready handshake and carry an address and a tiling type. The rewritten address comes back one cycle later through a registered response stage with its own valid/ready handshake. The response also carries the tiling type that was actually applied and the swizzle mode in the form reported to software. Two further outputs show the reported X and Y modes at all times. In every reported value the bit-17 modes are shown as their bit-17-free equivalents.

A configuration load is held pending until the response stage is empty. New requests are refused while the load is pending, so no access ever mixes old and new modes.

Top module: `tiled_swizzler`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and both reported modes are 0 (none).
- R2: A request with tiling code 0 (linear) or 3 (reserved) returns its address unchanged, with response tiling 0 and response mode 0.
- R3: For a tiled request, the response address equals the request address, except that bit 6 is XORed with the parity of the address bits its mode selects. Mode codes: 0 none, 1 {9}, 2 {9,10}, 3 {9,11}, 4 {9,10,11}, 5 {9,17}, 6 {9,10,17}, 7 unknown. Tiling codes: 1 X, 2 Y.
- R4: Configuration field `cfg_raw[1:0]` gives the channel layout: 0 single, 1 asymmetric dual, 2 interleaved dual, 3 flexible. Layouts 0 and 1 give mode none for both tiling types.
- R5: Layout 2 works as follows. With `cfg_raw[2]` (CPU XOR off) set, X uses mode 2 and Y uses mode 1. Otherwise `cfg_raw[3]` picks the CPU XOR source. A value of 0 means bit 11: X uses mode 4 and Y uses mode 3. A value of 1 means bit 17: X uses mode 6 and Y uses mode 5.
- R6: Layout 3 gives X mode 2 and Y mode 1 when `cfg_size_match` is 1, and none for both when it is 0.
- R7: A configuration word of all ones sets both modes to unknown (reported as 7). A tiled request made in that state is returned unchanged, with tiling 0 and mode 0.
- R8: Reported modes (`rpt_x_mode`, `rpt_y_mode`, `rsp_mode`) show 5 as 1 and 6 as 2. The address itself is still swizzled with the full mode.
- R9: A request accepted at clock edge k is presented at `rsp_valid` after edge k. It holds steady while `rsp_ready` is 0. `req_ready` is 1 exactly when the response stage is empty or being drained and no load is pending.
- R10: A `cfg_load` pulse marks a load pending and refuses requests. The modes change at the first edge after that with an empty response stage, so an idle block shows the new modes two edges after the load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_raw | input | CFG_W | Channel configuration word |
| cfg_size_match | input | 1 | Both channels hold equally sized memory |
| cfg_load | input | 1 | Capture the configuration (one-cycle pulse) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Request address |
| req_tiling | input | 2 | Tiling type of the request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer can take it |
| rsp_addr | output | ADDR_W | Swizzled address |
| rsp_tiling | output | 2 | Tiling type actually applied |
| rsp_mode | output | 3 | Reported mode used for this response |
| rpt_x_mode | output | 3 | Reported mode for X-tiled surfaces |
| rpt_y_mode | output | 3 | Reported mode for Y-tiled surfaces |

## Verification
Responses appear one edge after acceptance, and reported modes change two edges after a load when the block is idle. While a response waits, mode changes are delayed by one further edge after the drain. The bench drives inputs one time unit after each falling edge and samples on the falling edge. A behavioural model advanced on each rising edge predicts `req_ready`, the response fields and the reported modes for that same half-cycle. Directed checks are placed at the exact falling edge after the edge that should produce the result, including the drain-then-apply sequence under back-pressure.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [2:0] {
        SWZ_NONE      = 3'd0,
        SWZ_9         = 3'd1,
        SWZ_9_10      = 3'd2,
        SWZ_9_11      = 3'd3,
        SWZ_9_10_11   = 3'd4,
        SWZ_9_17      = 3'd5,
        SWZ_9_10_17   = 3'd6,
        SWZ_UNKNOWN   = 3'd7
    } swz_mode_e;

    typedef enum logic [1:0] {
        TILE_LINEAR = 2'd0,
        TILE_X      = 2'd1,
        TILE_Y      = 2'd2,
        TILE_RSVD   = 2'd3
    } tile_e;

    typedef enum logic [1:0] {
        LAYOUT_SINGLE      = 2'd0,
        LAYOUT_ASYM        = 2'd1,
        LAYOUT_INTERLEAVED = 2'd2,
        LAYOUT_FLEX        = 2'd3
    } layout_e;

    typedef struct packed {
        swz_mode_e x;
        swz_mode_e y;
    } mode_pair_t;

    // configuration word field positions
    localparam int FLD_LAYOUT_LSB = 0;
    localparam int FLD_XOR_OFF    = 2;
    localparam int FLD_XOR_SRC    = 3;
    localparam int CFG_MIN_W      = 4;

    // bit that receives the folded parity
    localparam int TGT_BIT = 6;

    // software-visible form: bit-17 contributions are hidden
    function automatic swz_mode_e hide_bit17(input swz_mode_e m);
        case (m)
            SWZ_9_17:    return SWZ_9;
            SWZ_9_10_17: return SWZ_9_10;
            default:     return m;
        endcase
    endfunction

endpackage

// File: rtl/swz_mode_decode.sv
module swz_mode_decode
    import swz_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic [CFG_W-1:0] cfg_raw,
    input  logic             cfg_size_match,
    output mode_pair_t       modes
);

    layout_e layout;

    always_comb begin
        layout  = layout_e'(cfg_raw[FLD_LAYOUT_LSB +: 2]);
        modes.x = SWZ_NONE;
        modes.y = SWZ_NONE;
        if (&cfg_raw) begin
            // configuration unreadable: tiling cannot be trusted
            modes.x = SWZ_UNKNOWN;
            modes.y = SWZ_UNKNOWN;
        end else begin
            case (layout)
                LAYOUT_INTERLEAVED: begin
                    if (cfg_raw[FLD_XOR_OFF]) begin
                        modes.x = SWZ_9_10;
                        modes.y = SWZ_9;
                    end else if (cfg_raw[FLD_XOR_SRC]) begin
                        modes.x = SWZ_9_10_17;
                        modes.y = SWZ_9_17;
                    end else begin
                        modes.x = SWZ_9_10_11;
                        modes.y = SWZ_9_11;
                    end
                end
                LAYOUT_FLEX: begin
                    if (cfg_size_match) begin
                        modes.x = SWZ_9_10;
                        modes.y = SWZ_9;
                    end
                end
                default: begin
                    modes.x = SWZ_NONE;
                    modes.y = SWZ_NONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/swz_bit_merge.sv
module swz_bit_merge
    import swz_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  swz_mode_e         mode,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int NSRC = 4;
    localparam int SRC_POS [NSRC] = '{9, 10, 11, 17};

    logic [NSRC-1:0] sel;
    logic [NSRC-1:0] term;

    // sel[0]=bit 9, sel[1]=bit 10, sel[2]=bit 11, sel[3]=bit 17
    always_comb begin
        case (mode)
            SWZ_9:       sel = 4'b0001;
            SWZ_9_10:    sel = 4'b0011;
            SWZ_9_11:    sel = 4'b0101;
            SWZ_9_10_11: sel = 4'b0111;
            SWZ_9_17:    sel = 4'b1001;
            SWZ_9_10_17: sel = 4'b1011;
            default:     sel = 4'b0000;
        endcase
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign term[i] = sel[i] & addr_in[SRC_POS[i]];
    end

    always_comb begin
        addr_out          = addr_in;
        addr_out[TGT_BIT] = addr_in[TGT_BIT] ^ (^term);
    end

endmodule

// File: rtl/tiled_swizzler.sv
module tiled_swizzler
    import swz_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_raw,
    input  logic              cfg_size_match,
    input  logic              cfg_load,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_tiling,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [1:0]        rsp_tiling,
    output logic [2:0]        rsp_mode,
    output logic [2:0]        rpt_x_mode,
    output logic [2:0]        rpt_y_mode
);

    typedef struct packed {
        logic              rsp_valid;
        logic [ADDR_W-1:0] rsp_addr;
        tile_e             rsp_tiling;
        swz_mode_e         rsp_mode;
        mode_pair_t        act;
        mode_pair_t        pend_modes;
        logic              pend;
    } state_t;

    state_t     st_d, st_q;
    mode_pair_t dec_modes;
    tile_e      tiling;
    swz_mode_e  sel_mode;
    swz_mode_e  merge_mode;
    logic       tiled_ok;
    logic       accept;
    logic [ADDR_W-1:0] merged_addr;

    swz_mode_decode #(.CFG_W(CFG_W)) u_decode (
        .cfg_raw        (cfg_raw),
        .cfg_size_match (cfg_size_match),
        .modes          (dec_modes)
    );

    swz_bit_merge #(.ADDR_W(ADDR_W)) u_merge (
        .addr_in  (req_addr),
        .mode     (merge_mode),
        .addr_out (merged_addr)
    );

    always_comb begin
        tiling   = tile_e'(req_tiling);
        case (tiling)
            TILE_X:  sel_mode = st_q.act.x;
            TILE_Y:  sel_mode = st_q.act.y;
            default: sel_mode = SWZ_NONE;
        endcase
        tiled_ok   = ((tiling == TILE_X) || (tiling == TILE_Y)) &&
                     (sel_mode != SWZ_UNKNOWN);
        merge_mode = tiled_ok ? sel_mode : SWZ_NONE;

        req_ready = (!st_q.rsp_valid || rsp_ready) && !st_q.pend;
        accept    = req_valid && req_ready;

        st_d = st_q;

        // response stage
        if (accept) begin
            st_d.rsp_valid  = 1'b1;
            st_d.rsp_addr   = merged_addr;
            st_d.rsp_tiling = tiled_ok ? tiling : TILE_LINEAR;
            st_d.rsp_mode   = tiled_ok ? hide_bit17(sel_mode) : SWZ_NONE;
        end else if (rsp_ready) begin
            st_d.rsp_valid  = 1'b0;
        end

        // pending modes take effect only with an empty response stage
        if (st_q.pend && !st_q.rsp_valid) begin
            st_d.act  = st_q.pend_modes;
            st_d.pend = 1'b0;
        end

        if (cfg_load) begin
            st_d.pend       = 1'b1;
            st_d.pend_modes = dec_modes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_addr   = st_q.rsp_addr;
    assign rsp_tiling = st_q.rsp_tiling;
    assign rsp_mode   = st_q.rsp_mode;
    assign rpt_x_mode = hide_bit17(st_q.act.x);
    assign rpt_y_mode = hide_bit17(st_q.act.y);

endmodule

// File: rtl/swz_checker.sv
module swz_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_tiling,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [1:0]        rsp_tiling,
    input logic [2:0]        rsp_mode,
    input logic [2:0]        rpt_x_mode,
    input logic [2:0]        rpt_y_mode
);

    localparam logic [ADDR_W-1:0] KEEP_MASK = ~({{(ADDR_W-1){1'b0}}, 1'b1} << 6);

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_mode)); // R9

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid); // R9

    AST_LINEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_tiling == 2'd0 || req_tiling == 2'd3)
        |=> rsp_addr == $past(req_addr) && rsp_tiling == 2'd0 && rsp_mode == 3'd0); // R2

    AST_ONLY_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> ((rsp_addr ^ $past(req_addr)) & KEEP_MASK) == '0); // R3

    AST_NO_B17_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_x_mode != 3'd5 && rpt_x_mode != 3'd6 &&
        rpt_y_mode != 3'd5 && rpt_y_mode != 3'd6); // R8

    AST_RSP_MODE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_mode != 3'd5 && rsp_mode != 3'd6 && rsp_mode != 3'd7); // R7

    AST_MODES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> $stable(rpt_x_mode) && $stable(rpt_y_mode)); // R10

endmodule

bind tiled_swizzler swz_checker #(.ADDR_W(ADDR_W)) u_swz_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_tiling (req_tiling),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_addr   (rsp_addr),
    .rsp_tiling (rsp_tiling),
    .rsp_mode   (rsp_mode),
    .rpt_x_mode (rpt_x_mode),
    .rpt_y_mode (rpt_y_mode)
);

// File: tb/test_tiled_swizzler.sv
module test_tiled_swizzler;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_raw = '0;
    logic        cfg_size_match = 1'b0;
    logic        cfg_load = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_tiling = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_tiling;
    logic [2:0]  rsp_mode;
    logic [2:0]  rpt_x_mode;
    logic [2:0]  rpt_y_mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiled_swizzler i_tiled_swizzler (
        .clk(clk), .rst_n(rst_n), .cfg_raw(cfg_raw), .cfg_size_match(cfg_size_match),
        .cfg_load(cfg_load), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_tiling(req_tiling), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_tiling(rsp_tiling),
        .rsp_mode(rsp_mode), .rpt_x_mode(rpt_x_mode), .rpt_y_mode(rpt_y_mode)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_x, m_y, m_px, m_py;
    bit          m_valid, m_pend;
    logic [31:0] m_addr;
    int          m_til, m_mode;

    function automatic void ref_modes(input logic [7:0] raw, input bit match, output int mx, output int my);
        mx = 0; my = 0;
        if (raw == 8'hFF) begin mx = 7; my = 7; end
        else if (raw[1:0] == 2'd2) begin
            if (raw[2])      begin mx = 2; my = 1; end
            else if (raw[3]) begin mx = 6; my = 5; end
            else             begin mx = 4; my = 3; end
        end else if (raw[1:0] == 2'd3 && match) begin mx = 2; my = 1; end
    endfunction

    function automatic int ref_hide(input int m);
        if (m == 5) return 1;
        if (m == 6) return 2;
        return m;
    endfunction

    function automatic logic [31:0] ref_swz(input logic [31:0] a, input int m);
        logic p;
        logic [31:0] r;
        r = a;
        if (m == 0) return r;
        p = a[9];
        if (m == 2 || m == 4 || m == 6) p = p ^ a[10];
        if (m == 3 || m == 4)           p = p ^ a[11];
        if (m == 5 || m == 6)           p = p ^ a[17];
        r[6] = a[6] ^ p;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_x = 0; m_y = 0; m_px = 0; m_py = 0;
            m_valid = 0; m_pend = 0; m_addr = '0; m_til = 0; m_mode = 0;
        end else begin
            bit old_v, old_p, rdy;
            int sm;
            bit tiled;
            old_v = m_valid;
            old_p = m_pend;
            rdy   = (!m_valid || rsp_ready) && !m_pend;
            if (req_valid && rdy) begin
                sm    = (req_tiling == 2'd1) ? m_x : (req_tiling == 2'd2) ? m_y : 0;
                tiled = (req_tiling == 2'd1 || req_tiling == 2'd2) && sm != 7;
                m_addr  = tiled ? ref_swz(req_addr, sm) : req_addr;
                m_til   = tiled ? int'(req_tiling) : 0;
                m_mode  = tiled ? ref_hide(sm) : 0;
                m_valid = 1;
            end else if (rsp_ready) begin
                m_valid = 0;
            end
            if (old_p && !old_v) begin
                m_x = m_px; m_y = m_py; m_pend = 0;
            end
            if (cfg_load) begin
                ref_modes(cfg_raw, cfg_size_match, m_px, m_py);
                m_pend = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_rdy;
            exp_rdy = (!m_valid || rsp_ready) && !m_pend;
            chk(req_ready == exp_rdy, "R10 model req_ready", 32'(req_ready), 32'(exp_rdy));
            chk(rsp_valid == m_valid, "R9 model rsp_valid", 32'(rsp_valid), 32'(m_valid));
            if (m_valid) begin
                chk(rsp_addr == m_addr, "R3 model rsp_addr", rsp_addr, m_addr);
                chk(int'(rsp_tiling) == m_til, "R7 model rsp_tiling", 32'(rsp_tiling), 32'(m_til));
                chk(int'(rsp_mode) == m_mode, "R8 model rsp_mode", 32'(rsp_mode), 32'(m_mode));
            end
            chk(int'(rpt_x_mode) == ref_hide(m_x), "R8 model rpt_x_mode", 32'(rpt_x_mode), 32'(ref_hide(m_x)));
            chk(int'(rpt_y_mode) == ref_hide(m_y), "R8 model rpt_y_mode", 32'(rpt_y_mode), 32'(ref_hide(m_y)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic load_cfg(input logic [7:0] raw, input bit match);
        cfg_raw = raw; cfg_size_match = match; cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
        tick();
    endtask

    task automatic send(input logic [31:0] a, input logic [1:0] t);
        while (!req_ready) tick();
        req_valid = 1'b1; req_addr = a; req_tiling = t;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input logic [31:0] a, input logic [1:0] t, input logic [2:0] m, input string tag);
        chk(rsp_valid == 1'b1, tag, 32'(rsp_valid), 32'd1);
        chk(rsp_addr == a, tag, rsp_addr, a);
        chk(rsp_tiling == t, tag, 32'(rsp_tiling), 32'(t));
        chk(rsp_mode == m, tag, 32'(rsp_mode), 32'(m));
    endtask

    task automatic expect_rpt(input logic [2:0] x, input logic [2:0] y, input string tag);
        chk(rpt_x_mode == x, tag, 32'(rpt_x_mode), 32'(x));
        chk(rpt_y_mode == y, tag, 32'(rpt_y_mode), 32'(y));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
        expect_rpt(3'd0, 3'd0, "R1 reported modes");

        // R5 interleaved, CPU XOR off
        load_cfg(8'b0000_0110, 1'b0);
        expect_rpt(3'd2, 3'd1, "R5 xor-off modes");
        send(32'h0000_0600, 2'd1); expect_rsp(32'h0000_0600, 2'd1, 3'd2, "R3 X 9^10");
        send(32'h0000_0600, 2'd2); expect_rsp(32'h0000_0640, 2'd2, 3'd1, "R3 Y 9");
        send(32'h1234_5640, 2'd0); expect_rsp(32'h1234_5640, 2'd0, 3'd0, "R2 linear");
        send(32'h0000_0200, 2'd3); expect_rsp(32'h0000_0200, 2'd0, 3'd0, "R2 reserved");

        // R5 CPU XOR from bit 11
        load_cfg(8'b0000_0010, 1'b0);
        expect_rpt(3'd4, 3'd3, "R5 bit11 modes");
        send(32'h0000_0A00, 2'd1); expect_rsp(32'h0000_0A00, 2'd1, 3'd4, "R3 X 9^10^11");
        send(32'h0000_0800, 2'd2); expect_rsp(32'h0000_0840, 2'd2, 3'd3, "R3 Y 9^11");

        // R5/R8 CPU XOR from bit 17, reported without bit 17
        load_cfg(8'b0000_1010, 1'b0);
        expect_rpt(3'd2, 3'd1, "R8 bit17 hidden in report");
        send(32'h0002_0000, 2'd2); expect_rsp(32'h0002_0040, 2'd2, 3'd1, "R8 Y 9^17 swizzled");
        send(32'h0002_0040, 2'd1); expect_rsp(32'h0002_0000, 2'd1, 3'd2, "R8 X 9^10^17 swizzled");

        // R4 single and asymmetric layouts
        load_cfg(8'b0000_0000, 1'b1);
        expect_rpt(3'd0, 3'd0, "R4 single channel");
        send(32'h0000_0200, 2'd1); expect_rsp(32'h0000_0200, 2'd1, 3'd0, "R4 X unchanged");
        load_cfg(8'b0000_0001, 1'b1);
        expect_rpt(3'd0, 3'd0, "R4 asymmetric");

        // R6 flexible layout
        load_cfg(8'b0000_0011, 1'b1);
        expect_rpt(3'd2, 3'd1, "R6 sizes match");
        load_cfg(8'b0000_0011, 1'b0);
        expect_rpt(3'd0, 3'd0, "R6 sizes differ");

        // R7 unreadable configuration
        load_cfg(8'hFF, 1'b1);
        expect_rpt(3'd7, 3'd7, "R7 unknown modes");
        send(32'h0000_0600, 2'd1); expect_rsp(32'h0000_0600, 2'd0, 3'd0, "R7 forced linear");

        // R9/R10 back-pressure and deferred mode change
        load_cfg(8'b0000_0110, 1'b0);
        rsp_ready = 1'b0;
        send(32'h0000_0200, 2'd2);
        chk(req_ready == 1'b0, "R9 full stage refuses", 32'(req_ready), 0);
        cfg_raw = 8'b0000_0011; cfg_size_match = 1'b0; cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
        tick(); tick();
        chk(rsp_addr == 32'h0000_0240, "R9 held response", rsp_addr, 32'h0000_0240);
        expect_rpt(3'd2, 3'd1, "R10 modes held while busy");
        rsp_ready = 1'b1;
        chk(req_ready == 1'b0, "R10 pending load refuses", 32'(req_ready), 0);
        tick();
        expect_rpt(3'd2, 3'd1, "R10 not yet applied at drain");
        tick();
        expect_rpt(3'd0, 3'd0, "R10 applied after drain");
        chk(req_ready == 1'b1, "R10 ready after apply", 32'(req_ready), 1);

        // mixed traffic, compared against the model every cycle
        s = 32'h1ACE_0001;
        for (int i = 0; i < 300; i++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            req_valid      = s[0];
            req_addr       = s ^ {s[15:0], s[31:16]};
            req_tiling     = s[5:4];
            rsp_ready      = s[8] | s[9];
            cfg_load       = (i % 23 == 7);
            cfg_raw        = (i % 46 == 7) ? 8'hFF : {4'h0, s[19:16]};
            cfg_size_match = s[3];
            tick();
        end
        req_valid = 1'b0; cfg_load = 1'b0; rsp_ready = 1'b1;
        repeat (4) tick();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule